// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a 16-bit set of sticky status flags that tell software why the device last came out of reset or last entered a low-power state. Hardware events arrive as single-cycle pulses: power-on, brown-out, external reset pin, reset instruction, watchdog timeout, trap conflict, illegal opcode, configuration mismatch, and the sleep and idle commands. A deep-sleep enable input decides whether a sleep command counts as sleep or as deep sleep. Each flag has its own set event and its own clearing event, and some flags are cleared only by software.

Software reads the register on `flags_o` and may set or clear any implemented flag through a one-cycle write port. A write never raises a reset. The block also drives a one-cycle combined reset request, the effective watchdog enable, and a registered 3-bit oscillator selection. That selection depends on the kind of reset that occurred and on whether clock switching is enabled.

Top module: `rst_cause_reg`

## Requirements
- R1: Only these bits are implemented: 15 trap conflict, 14 illegal opcode, 10 deep sleep, 9 configuration mismatch, 7 external pin, 6 reset instruction, 4 watchdog timeout, 3 sleep, 2 idle, 1 brown-out, 0 power-on (mask 0xC6DF). Every other bit of `flags_o` reads 0, even after software writes ones to it.
- R2: A power-on pulse sets bits 0 and 1. A brown-out pulse sets bit 1 only.
- R3: A power-on pulse clears bits 15, 14, 10, 9, 7, 6, 4, 3 and 2. No other hardware event clears bits 15, 14, 10, 9, 7, 6, 3 or 2.
- R4: A sleep command (with either value of deep-sleep enable) or an idle command clears bit 4.
- R5: Bits 0 and 1 are never cleared by hardware. Only a software write clears them.
- R6: A sleep command sets bit 10 when `dsleep_en_i` is 1 and sets bit 3 when it is 0. An idle command sets bit 2.
- R7: A write with `wr_en_i` high loads `wr_data_i` into the implemented bits on the next edge and never causes `rst_req_o` to go high.
- R8: Per bit, the priority is: a hardware set event, then a hardware clear event, then a software write. A bit that is set in the same cycle as a write of 0 reads 1 afterwards.
- R9: `rst_req_o` is high in the cycle after any power-on, brown-out, pin, reset-instruction, watchdog, trap, illegal-opcode or configuration-mismatch pulse. It stays low after sleep and idle commands.
- R10: `wdt_en_o` is 1 whenever `cfg_wdt_on_i` is 1. Otherwise it equals `sw_wdt_en_i`.
- R11: On a reset event, `osc_sel_o` loads `cfg_osc_i` when clock switching is disabled or when the event includes power-on or brown-out. Otherwise it loads `cur_osc_i`.
- R12: `osc_sel_o` holds its value in every cycle that has no reset event.
- R13: While `rst_ni` is low, `flags_o` is 0x0003, `rst_req_o` is 0 and `osc_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the block's own registers |
| ev_por_i | input | 1 | Power-on event pulse |
| ev_bor_i | input | 1 | Brown-out event pulse |
| ev_pin_i | input | 1 | External reset pin event pulse |
| ev_swrst_i | input | 1 | Reset instruction event pulse |
| ev_wdt_i | input | 1 | Watchdog timeout event pulse |
| ev_trap_i | input | 1 | Trap conflict event pulse |
| ev_illop_i | input | 1 | Illegal opcode or uninitialized register access pulse |
| ev_cfgmis_i | input | 1 | Configuration mismatch event pulse |
| cmd_sleep_i | input | 1 | Sleep command pulse |
| cmd_idle_i | input | 1 | Idle command pulse |
| dsleep_en_i | input | 1 | Deep-sleep enable, qualifies the sleep command |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Software write data |
| cfg_wdt_on_i | input | 1 | Configuration watchdog force-on |
| sw_wdt_en_i | input | 1 | Software watchdog enable |
| cfg_clksw_en_i | input | 1 | Clock switching enabled |
| cfg_osc_i | input | 3 | Configured new-oscillator field |
| cur_osc_i | input | 3 | Current-oscillator field |
| flags_o | output | 16 | Flag register value |
| rst_req_o | output | 1 | Combined reset request pulse |
| wdt_en_o | output | 1 | Effective watchdog enable |
| osc_sel_o | output | 3 | Oscillator selection after reset |

## Verification
The hardest cases to reach are the collisions: a set event, a clear event and a software write that all land on the same bit in one cycle. Examples are a watchdog timeout arriving together with a sleep command and a write, or a power-on arriving together with a trap. Directed cases build these collisions on purpose. A long run of sparse random pulses then mixes events, commands and writes freely. The bench compares every cycle against a bench model of the flag, request and oscillator rules, and the random run uses a changing current-oscillator input so that the hold behaviour of `osc_sel_o` is exercised.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
   localparam int FLAG_W = 16;

   localparam int B_POR    = 0;
   localparam int B_BOR    = 1;
   localparam int B_IDLE   = 2;
   localparam int B_SLEEP  = 3;
   localparam int B_WDT    = 4;
   localparam int B_SWRST  = 6;
   localparam int B_PIN    = 7;
   localparam int B_CFGMIS = 9;
   localparam int B_DSLEEP = 10;
   localparam int B_ILLOP  = 14;
   localparam int B_TRAP   = 15;

   localparam logic [FLAG_W-1:0] IMPL_MASK =
      (FLAG_W'(1) << B_POR)    | (FLAG_W'(1) << B_BOR)    |
      (FLAG_W'(1) << B_IDLE)   | (FLAG_W'(1) << B_SLEEP)  |
      (FLAG_W'(1) << B_WDT)    | (FLAG_W'(1) << B_SWRST)  |
      (FLAG_W'(1) << B_PIN)    | (FLAG_W'(1) << B_CFGMIS) |
      (FLAG_W'(1) << B_DSLEEP) | (FLAG_W'(1) << B_ILLOP)  |
      (FLAG_W'(1) << B_TRAP);

   typedef struct packed {
      logic por;
      logic bor;
      logic pin;
      logic swrst;
      logic wdt;
      logic trap;
      logic illop;
      logic cfgmis;
      logic sleep;
      logic idle;
      logic dsleep_en;
   } rc_evt_t;
endpackage

// File: rtl/rst_cause_bit.sv
module rst_cause_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   input  logic wr_i,
   input  logic wd_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= RST_VAL;
      else if (set_i)  q_q <= 1'b1;
      else if (clr_i)  q_q <= 1'b0;
      else if (wr_i)   q_q <= wd_i;
   end

   assign q_o = q_q;

   assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);
   assert_hw_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o);
   assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !clr_i && !wr_i) |=> $stable(q_o));
endmodule

// File: rtl/rst_cause_evmap.sv
module rst_cause_evmap
   import rst_cause_pkg::*;
(
   input  rc_evt_t           evt_i,
   output logic [FLAG_W-1:0] set_o,
   output logic [FLAG_W-1:0] clr_o,
   output logic              rst_any_o,
   output logic              cold_o
);
   localparam logic [FLAG_W-1:0] POR_CLR =
      (FLAG_W'(1) << B_TRAP)   | (FLAG_W'(1) << B_ILLOP) |
      (FLAG_W'(1) << B_DSLEEP) | (FLAG_W'(1) << B_CFGMIS) |
      (FLAG_W'(1) << B_PIN)    | (FLAG_W'(1) << B_SWRST) |
      (FLAG_W'(1) << B_WDT)    | (FLAG_W'(1) << B_SLEEP) |
      (FLAG_W'(1) << B_IDLE);

   always_comb begin
      set_o = '0;
      set_o[B_POR]    = evt_i.por;
      set_o[B_BOR]    = evt_i.por | evt_i.bor;
      set_o[B_PIN]    = evt_i.pin;
      set_o[B_SWRST]  = evt_i.swrst;
      set_o[B_WDT]    = evt_i.wdt;
      set_o[B_TRAP]   = evt_i.trap;
      set_o[B_ILLOP]  = evt_i.illop;
      set_o[B_CFGMIS] = evt_i.cfgmis;
      set_o[B_SLEEP]  = evt_i.sleep & ~evt_i.dsleep_en;
      set_o[B_DSLEEP] = evt_i.sleep & evt_i.dsleep_en;
      set_o[B_IDLE]   = evt_i.idle;

      clr_o = evt_i.por ? POR_CLR : '0;
      if (evt_i.sleep || evt_i.idle) clr_o[B_WDT] = 1'b1;
   end

   assign rst_any_o = evt_i.por | evt_i.bor | evt_i.pin | evt_i.swrst |
                      evt_i.wdt | evt_i.trap | evt_i.illop | evt_i.cfgmis;
   assign cold_o    = evt_i.por | evt_i.bor;

   always_comb begin
      assert_cold_keeps_R5: assert (clr_o[B_POR] == 1'b0 && clr_o[B_BOR] == 1'b0);
   end
endmodule

// File: rtl/rst_cause_oscsel.sv
module rst_cause_oscsel #(
   parameter int          OSC_W     = 3,
   parameter bit          HAS_CLKSW = 1'b1,
   parameter logic [OSC_W-1:0] OSC_RST = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rst_any_i,
   input  logic             cold_i,
   input  logic             clksw_en_i,
   input  logic [OSC_W-1:0] cfg_osc_i,
   input  logic [OSC_W-1:0] cur_osc_i,
   output logic [OSC_W-1:0] osc_sel_o
);
   logic [OSC_W-1:0] pick;
   logic [OSC_W-1:0] sel_q;

   generate
      if (HAS_CLKSW) begin : g_clksw
         assign pick = (!clksw_en_i || cold_i) ? cfg_osc_i : cur_osc_i;
      end else begin : g_fixed
         logic unused_sw;
         assign unused_sw = clksw_en_i ^ cold_i ^ (^cur_osc_i);
         assign pick = cfg_osc_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_q <= OSC_RST;
      else if (rst_any_i) sel_q <= pick;
   end

   assign osc_sel_o = sel_q;

   assert_osc_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rst_any_i |=> $stable(osc_sel_o));
   assert_osc_cold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_any_i && cold_i) |=> (osc_sel_o == $past(cfg_osc_i)));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_cause_pkg::*;
#(
   parameter int                OSC_W       = 3,
   parameter bit                HAS_CLKSW   = 1'b1,
   parameter logic [15:0]       RESET_FLAGS = 16'h0003,
   parameter logic [OSC_W-1:0]  OSC_RST     = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ev_por_i,
   input  logic              ev_bor_i,
   input  logic              ev_pin_i,
   input  logic              ev_swrst_i,
   input  logic              ev_wdt_i,
   input  logic              ev_trap_i,
   input  logic              ev_illop_i,
   input  logic              ev_cfgmis_i,
   input  logic              cmd_sleep_i,
   input  logic              cmd_idle_i,
   input  logic              dsleep_en_i,
   input  logic              wr_en_i,
   input  logic [15:0]       wr_data_i,
   input  logic              cfg_wdt_on_i,
   input  logic              sw_wdt_en_i,
   input  logic              cfg_clksw_en_i,
   input  logic [OSC_W-1:0]  cfg_osc_i,
   input  logic [OSC_W-1:0]  cur_osc_i,
   output logic [15:0]       flags_o,
   output logic              rst_req_o,
   output logic              wdt_en_o,
   output logic [OSC_W-1:0]  osc_sel_o
);
   if (OSC_W < 1) begin : g_bad_osc
      $error("rst_cause_reg: OSC_W must be at least 1");
   end
   if ((RESET_FLAGS & ~IMPL_MASK) != '0) begin : g_bad_rst
      $error("rst_cause_reg: RESET_FLAGS names an unimplemented bit");
   end

   rc_evt_t           evt;
   logic [FLAG_W-1:0] set_v, clr_v, q_v;
   logic              rst_any, cold;
   logic              req_q;

   assign evt = '{por: ev_por_i, bor: ev_bor_i, pin: ev_pin_i, swrst: ev_swrst_i,
                  wdt: ev_wdt_i, trap: ev_trap_i, illop: ev_illop_i,
                  cfgmis: ev_cfgmis_i, sleep: cmd_sleep_i, idle: cmd_idle_i,
                  dsleep_en: dsleep_en_i};

   rst_cause_evmap u_evmap (
      .evt_i     (evt),
      .set_o     (set_v),
      .clr_o     (clr_v),
      .rst_any_o (rst_any),
      .cold_o    (cold)
   );

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (IMPL_MASK[i]) begin : g_impl
         rst_cause_bit #(.RST_VAL(RESET_FLAGS[i])) u_bit (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .wr_i   (wr_en_i),
            .wd_i   (wr_data_i[i]),
            .q_o    (q_v[i])
         );
      end else begin : g_hole
         logic unused_bit;
         assign unused_bit = set_v[i] ^ clr_v[i] ^ wr_data_i[i];
         assign q_v[i] = 1'b0;
      end
   end

   assign flags_o = q_v;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= rst_any;
   end
   assign rst_req_o = req_q;

   assign wdt_en_o = cfg_wdt_on_i | sw_wdt_en_i;

   rst_cause_oscsel #(.OSC_W(OSC_W), .HAS_CLKSW(HAS_CLKSW), .OSC_RST(OSC_RST)) u_osc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rst_any_i  (rst_any),
      .cold_i     (cold),
      .clksw_en_i (cfg_clksw_en_i),
      .cfg_osc_i  (cfg_osc_i),
      .cur_osc_i  (cur_osc_i),
      .osc_sel_o  (osc_sel_o)
   );

   assert_unused_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o & ~IMPL_MASK) == '0);
   assert_no_req_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_por_i && !ev_bor_i && !ev_pin_i && !ev_swrst_i && !ev_wdt_i &&
       !ev_trap_i && !ev_illop_i && !ev_cfgmis_i) |=> !rst_req_o);
   assert_req_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_por_i || ev_wdt_i || ev_pin_i) |=> rst_req_o);
   assert_por_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[B_POR] && !wr_en_i) |=> flags_o[B_POR]);
   assert_wdt_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wdt_on_i |-> wdt_en_o);
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
   localparam logic [15:0] MASK = 16'hC6DF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic por, bor, pin, swr, wdt, trap, ill, cfm, slp, idl, dsen;
   logic we, cfg_wdt, sw_wdt, clksw;
   logic [15:0] wd;
   logic [2:0]  cfg_osc, cur_osc;
   logic [15:0] flags;
   logic        req, wdt_en;
   logic [2:0]  osc;

   int n_chk = 0, n_err = 0;
   logic [15:0] exp_f;
   logic        exp_req;
   logic [2:0]  exp_osc;

   always #5 clk = ~clk;

   rst_cause_reg dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ev_por_i(por), .ev_bor_i(bor), .ev_pin_i(pin),
      .ev_swrst_i(swr), .ev_wdt_i(wdt), .ev_trap_i(trap), .ev_illop_i(ill),
      .ev_cfgmis_i(cfm), .cmd_sleep_i(slp), .cmd_idle_i(idl), .dsleep_en_i(dsen),
      .wr_en_i(we), .wr_data_i(wd), .cfg_wdt_on_i(cfg_wdt), .sw_wdt_en_i(sw_wdt),
      .cfg_clksw_en_i(clksw), .cfg_osc_i(cfg_osc), .cur_osc_i(cur_osc),
      .flags_o(flags), .rst_req_o(req), .wdt_en_o(wdt_en), .osc_sel_o(osc));

   function automatic logic any_rst();
      return por | bor | pin | swr | wdt | trap | ill | cfm;
   endfunction

   function automatic logic [15:0] f_next(logic [15:0] f);
      logic [15:0] s, c, n;
      s = 16'h0;
      c = 16'h0;
      if (por)          s |= 16'h0003;
      if (bor)          s |= 16'h0002;
      if (pin)          s |= 16'h0080;
      if (swr)          s |= 16'h0040;
      if (wdt)          s |= 16'h0010;
      if (trap)         s |= 16'h8000;
      if (ill)          s |= 16'h4000;
      if (cfm)          s |= 16'h0200;
      if (slp && !dsen) s |= 16'h0008;
      if (slp && dsen)  s |= 16'h0400;
      if (idl)          s |= 16'h0004;
      if (por)          c |= 16'hC6DC;
      if (slp || idl)   c |= 16'h0010;
      n = we ? wd : f;
      n = (n & ~c) | s;
      return n & MASK;
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic chk_all(string tag);
      chk({tag, " flags"}, flags, exp_f);
      chk({tag, " req"}, {15'h0, req}, {15'h0, exp_req});
      chk({tag, " osc"}, {13'h0, osc}, {13'h0, exp_osc});
   endtask

   task automatic quiet();
      {por, bor, pin, swr, wdt, trap, ill, cfm, slp, idl, we} = '0;
      wd = '0;
   endtask

   task automatic tick();
      logic [15:0] nf;
      logic        nr;
      logic [2:0]  no;
      nf = f_next(exp_f);
      nr = any_rst();
      no = exp_osc;
      if (nr) no = (!clksw || por || bor) ? cfg_osc : cur_osc;
      @(posedge clk);
      @(negedge clk);
      exp_f = nf;
      exp_req = nr;
      exp_osc = no;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      quiet();
      dsen = 0; cfg_wdt = 0; sw_wdt = 0; clksw = 1; cfg_osc = 3'd2; cur_osc = 3'd5;
      exp_f = 16'h0003; exp_req = 0; exp_osc = 3'd0;
      repeat (3) @(negedge clk);
      chk_all("R13 reset");
      rst_n = 1;
      @(negedge clk);
      chk_all("R13 after release");

      // R1 and R7: write all ones
      we = 1; wd = 16'hFFFF; tick(); quiet();
      chk("R1 mask", flags, 16'hC6DF);
      chk("R7 no req on write", {15'h0, req}, 16'h0);
      we = 1; wd = 16'h0000; tick(); quiet();
      chk("R7 clear by write", flags, 16'h0000);

      // R2 brown-out then power-on
      bor = 1; tick(); quiet();
      chk("R2 bor only", flags, 16'h0002);
      chk("R9 req after bor", {15'h0, req}, 16'h1);
      chk("R11 bor cfg osc", {13'h0, osc}, 16'd2);
      tick();
      chk("R9 single pulse", {15'h0, req}, 16'h0);
      we = 1; wd = 16'hC6DC; tick(); quiet();
      por = 1; tick(); quiet();
      chk("R3 por clears", flags, 16'h0003);

      // R4 and R6 sleep variants
      wdt = 1; tick(); quiet();
      chk("R9 wdt flag", flags, 16'h0013);
      slp = 1; dsen = 0; tick(); quiet();
      chk("R4 R6 sleep", flags, 16'h000B);
      chk("R9 no req on sleep", {15'h0, req}, 16'h0);
      wdt = 1; tick(); quiet();
      slp = 1; dsen = 1; tick(); quiet();
      chk("R6 deep sleep", flags, 16'h040B);
      idl = 1; tick(); quiet();
      chk("R6 idle", flags, 16'h040F);

      // R8 collisions
      wdt = 1; we = 1; wd = 16'h0000; tick(); quiet();
      chk("R8 set beats write", flags, 16'h0010);
      slp = 1; dsen = 0; we = 1; wd = 16'h0010; tick(); quiet();
      chk("R8 clear beats write", flags, 16'h0008);
      pin = 1; tick(); quiet();
      chk("R5 bor por stay clear", flags & 16'h0003, 16'h0000);

      // R10
      cfg_wdt = 1; sw_wdt = 0; #1 chk("R10 forced", {15'h0, wdt_en}, 16'h1);
      cfg_wdt = 0; sw_wdt = 0; #1 chk("R10 sw off", {15'h0, wdt_en}, 16'h0);
      sw_wdt = 1; #1 chk("R10 sw on", {15'h0, wdt_en}, 16'h1);

      // R11 and R12 oscillator
      @(negedge clk);
      clksw = 1; cur_osc = 3'd5; cfg_osc = 3'd2; pin = 1; tick(); quiet();
      chk("R11 pin keeps cur", {13'h0, osc}, 16'd5);
      cur_osc = 3'd1; tick();
      chk("R12 hold", {13'h0, osc}, 16'd5);
      clksw = 0; swr = 1; tick(); quiet();
      chk("R11 no clksw cfg", {13'h0, osc}, 16'd2);
      clksw = 1; trap = 1; por = 1; tick(); quiet();
      chk("R11 por wins", {13'h0, osc}, 16'd2);
      chk("R8 por with trap", flags & 16'h8003, 16'h8003);

      // random mix
      void'($urandom(32'h1234_5EED));
      for (int k = 0; k < 3000; k++) begin
         por  = ($urandom % 40) == 0;
         bor  = ($urandom % 30) == 0;
         pin  = ($urandom % 16) == 0;
         swr  = ($urandom % 16) == 0;
         wdt  = ($urandom % 8) == 0;
         trap = ($urandom % 16) == 0;
         ill  = ($urandom % 16) == 0;
         cfm  = ($urandom % 16) == 0;
         slp  = ($urandom % 8) == 0;
         idl  = ($urandom % 8) == 0;
         dsen = $urandom % 2;
         we   = ($urandom % 6) == 0;
         wd   = 16'($urandom);
         clksw = ($urandom % 4) != 0;
         cfg_osc = 3'($urandom);
         cur_osc = 3'($urandom);
         tick();
         chk_all("R2/R3/R4/R5/R6/R8/R9/R11/R12 random");
      end
      quiet();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule